// File: doc/BRIEF.md
# Variable-Latency In-Order Pipeline with Execute Forwarding

This block is a four-stage in-order pipeline for three-register arithmetic instructions. An instruction is offered on a valid/ready input and carries an opcode, one destination register and two source registers. It is decoded in the cycle it is accepted. It reads its operands in the following cycle, then spends an opcode-dependent number of cycles in a single execute unit, and is written back one cycle later. Each retirement is reported on a result port, together with the index of the cycle in which it retires.

The execute unit is not pipelined. A long multiply or divide holds the next instruction in operand fetch and holds back everything behind it. Read-after-write dependencies are resolved without waiting for writeback. A result is forwarded in the final execute cycle of its producer, and a register written at a clock edge is visible to an operand read in that same cycle. The register file resets to known values, so a stream of instructions gives fully predictable results.

Top module: `varlat_pipe`

## Requirements
- R1: After reset, in_ready is 1, ret_valid is 0, and register k holds the value k, zero-extended to the data width.
- R2: The opcode is 2 bits: 00 adds, 01 subtracts (rs1 minus rs2, modulo 2^DW), 10 multiplies (low DW bits of the product), 11 divides unsigned (rs1 / rs2). A divisor of zero gives all ones. The result goes to rd.
- R3: Decode, operand fetch and writeback take one cycle each. Execute takes 1 cycle for add and subtract, 3 for multiply and 5 for divide. An unstalled instruction accepted in cycle c therefore retires in cycle c+2+L.
- R4: Only one instruction occupies execute at a time. The next instruction waits in operand fetch, with in_ready low, and enters execute in the cycle after the last execute cycle of its predecessor.
- R5: A source that names the destination of the instruction in execute takes that result in the producer's final execute cycle. The dependent instruction enters execute in the next cycle.
- R6: When writeback updates a register in the same cycle that operand fetch reads it, operand fetch gets the new value.
- R7: Instructions retire in program order, at most one per cycle. ret_rd and ret_data give the destination and the value written.
- R8: The cycle counter reads 0 in the cycle in which the first instruction after reset is accepted, and it rises by one every cycle after that. ret_cycle is its value in the retirement cycle. For MUL R2,R0,R1; DIV R5,R3,R4; ADD R2,R5,R2; SUB R5,R2,R6 offered back to back, the last retirement reports cycle 12.
- R9: While in_valid is 0, no instruction is taken and the counter does not start, whatever values the instruction fields hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction taken this cycle if in_valid |
| in_op | input | 2 | Opcode |
| in_rd | input | RW (4) | Destination register |
| in_rs1 | input | RW (4) | First source register |
| in_rs2 | input | RW (4) | Second source register |
| ret_valid | output | 1 | An instruction retires this cycle |
| ret_rd | output | RW (4) | Destination of the retiring instruction |
| ret_data | output | DW (16) | Value written |
| ret_cycle | output | CNTW (16) | Cycle index of this retirement |

## Verification
Two events can fall in the same cycle: an older result being written back, and a younger instruction reading that same register in operand fetch. The final execute cycle of a producer can also coincide with a dependent instruction fetching its operands. Short programs are streamed back to back so that an instruction two slots behind a producer fetches operands in the producer's writeback cycle. Chained dependencies put the consumer in operand fetch during the producer's last execute cycle. The bench's own in-order model predicts each retired value and cycle index, and every retirement is compared against it.

// File: rtl/vlp_pkg.sv
package vlp_pkg;
    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_SUB = 2'b01,
        OP_MUL = 2'b10,
        OP_DIV = 2'b11
    } op_e;
endpackage

// File: rtl/vlp_regfile.sv
module vlp_regfile #(
    parameter int DW   = 16,
    parameter int NREG = 16,
    localparam int RW  = $clog2(NREG)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [RW-1:0]          waddr,
    input  logic [DW-1:0]          wdata,
    input  logic [1:0][RW-1:0]     raddr,
    output logic [1:0][DW-1:0]     rdata
);
    logic [NREG-1:0][DW-1:0] rf_d, rf_q;

    always_comb begin
        rf_d = rf_q;
        if (we) rf_d[waddr] = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NREG; k++) rf_q[k] <= DW'(k);
        end else begin
            rf_q <= rf_d;
        end
    end

    for (genvar p = 0; p < 2; p++) begin : g_rd
        assign rdata[p] = rf_q[raddr[p]];
    end
endmodule

// File: rtl/vlp_opsel.sv
module vlp_opsel #(
    parameter int DW = 16,
    parameter int RW = 4
) (
    input  logic [RW-1:0] src,
    input  logic [DW-1:0] rf_val,
    input  logic          ex_done,
    input  logic [RW-1:0] ex_rd,
    input  logic [DW-1:0] ex_res,
    input  logic          wb_we,
    input  logic [RW-1:0] wb_rd,
    input  logic [DW-1:0] wb_data,
    output logic [DW-1:0] val
);
    always_comb begin
        if (ex_done && ex_rd == src)      val = ex_res;
        else if (wb_we && wb_rd == src)   val = wb_data;
        else                              val = rf_val;
    end
endmodule

// File: rtl/vlp_exec.sv
module vlp_exec
    import vlp_pkg::*;
#(
    parameter int DW         = 16,
    parameter int RW         = 4,
    parameter int LAT_ADDSUB = 1,
    parameter int LAT_MUL    = 3,
    parameter int LAT_DIV    = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue,
    input  op_e           issue_op,
    input  logic [RW-1:0] issue_rd,
    input  logic [DW-1:0] issue_a,
    input  logic [DW-1:0] issue_b,
    output logic          busy,
    output logic          last,
    output logic [RW-1:0] res_rd,
    output logic [DW-1:0] res
);
    localparam int MAXLAT = (LAT_DIV > LAT_MUL) ? ((LAT_DIV > LAT_ADDSUB) ? LAT_DIV : LAT_ADDSUB)
                                                : ((LAT_MUL > LAT_ADDSUB) ? LAT_MUL : LAT_ADDSUB);
    localparam int CW = $clog2(MAXLAT + 1);

    typedef struct packed {
        logic          valid;
        op_e           op;
        logic [RW-1:0] rd;
        logic [DW-1:0] a;
        logic [DW-1:0] b;
        logic [CW-1:0] cnt;
    } ex_t;

    ex_t s_d, s_q;

    function automatic logic [CW-1:0] lat_of(input op_e op);
        case (op)
            OP_MUL:  return CW'(LAT_MUL);
            OP_DIV:  return CW'(LAT_DIV);
            default: return CW'(LAT_ADDSUB);
        endcase
    endfunction

    assign busy   = s_q.valid;
    assign last   = s_q.valid && (s_q.cnt == CW'(1));
    assign res_rd = s_q.rd;

    logic [2*DW-1:0] prod;
    assign prod = {{DW{1'b0}}, s_q.a} * {{DW{1'b0}}, s_q.b};

    always_comb begin
        case (s_q.op)
            OP_ADD:  res = s_q.a + s_q.b;
            OP_SUB:  res = s_q.a - s_q.b;
            OP_MUL:  res = prod[DW-1:0];
            default: res = (s_q.b == '0) ? '1 : s_q.a / s_q.b;
        endcase
    end

    always_comb begin
        s_d = s_q;
        if (issue) begin
            s_d.valid = 1'b1;
            s_d.op    = issue_op;
            s_d.rd    = issue_rd;
            s_d.a     = issue_a;
            s_d.b     = issue_b;
            s_d.cnt   = lat_of(issue_op);
        end else if (last) begin
            s_d.valid = 1'b0;
        end else if (s_q.valid) begin
            s_d.cnt = s_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R4
    issue_when_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> (!s_q.valid || last));

    // R4
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.valid && !last) |=> (s_q.valid && $stable(s_q.rd) && $stable(s_q.op)));

    // R3
    cnt_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.valid |-> (s_q.cnt != '0));
endmodule

// File: rtl/varlat_pipe.sv
module varlat_pipe
    import vlp_pkg::*;
#(
    parameter int DW         = 16,
    parameter int NREG       = 16,
    parameter int CNTW       = 16,
    parameter int LAT_ADDSUB = 1,
    parameter int LAT_MUL    = 3,
    parameter int LAT_DIV    = 5,
    localparam int RW        = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [1:0]      in_op,
    input  logic [RW-1:0]   in_rd,
    input  logic [RW-1:0]   in_rs1,
    input  logic [RW-1:0]   in_rs2,
    output logic            ret_valid,
    output logic [RW-1:0]   ret_rd,
    output logic [DW-1:0]   ret_data,
    output logic [CNTW-1:0] ret_cycle
);
    typedef struct packed {
        logic            of_valid;
        op_e             of_op;
        logic [RW-1:0]   of_rd;
        logic [RW-1:0]   of_rs1;
        logic [RW-1:0]   of_rs2;
        logic            wb_valid;
        logic [RW-1:0]   wb_rd;
        logic [DW-1:0]   wb_data;
        logic [CNTW-1:0] cyc;
        logic            run;
    } st_t;

    st_t st_d, st_q;

    logic            ex_busy, ex_last;
    logic [RW-1:0]   ex_rd;
    logic [DW-1:0]   ex_res;
    logic            of_adv, accept;
    logic [1:0][RW-1:0] src_idx;
    logic [1:0][DW-1:0] rf_val, opnd;

    assign of_adv   = st_q.of_valid && (!ex_busy || ex_last);
    assign in_ready = !st_q.of_valid || of_adv;
    assign accept   = in_valid && in_ready;

    assign src_idx[0] = st_q.of_rs1;
    assign src_idx[1] = st_q.of_rs2;

    vlp_regfile #(.DW(DW), .NREG(NREG)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (st_q.wb_valid),
        .waddr (st_q.wb_rd),
        .wdata (st_q.wb_data),
        .raddr (src_idx),
        .rdata (rf_val)
    );

    for (genvar g = 0; g < 2; g++) begin : g_opsel
        vlp_opsel #(.DW(DW), .RW(RW)) u_sel (
            .src     (src_idx[g]),
            .rf_val  (rf_val[g]),
            .ex_done (ex_last),
            .ex_rd   (ex_rd),
            .ex_res  (ex_res),
            .wb_we   (st_q.wb_valid),
            .wb_rd   (st_q.wb_rd),
            .wb_data (st_q.wb_data),
            .val     (opnd[g])
        );
    end

    vlp_exec #(
        .DW(DW), .RW(RW),
        .LAT_ADDSUB(LAT_ADDSUB), .LAT_MUL(LAT_MUL), .LAT_DIV(LAT_DIV)
    ) u_ex (
        .clk      (clk),
        .rst_n    (rst_n),
        .issue    (of_adv),
        .issue_op (st_q.of_op),
        .issue_rd (st_q.of_rd),
        .issue_a  (opnd[0]),
        .issue_b  (opnd[1]),
        .busy     (ex_busy),
        .last     (ex_last),
        .res_rd   (ex_rd),
        .res      (ex_res)
    );

    always_comb begin
        st_d = st_q;
        if (accept) begin
            st_d.of_valid = 1'b1;
            st_d.of_op    = op_e'(in_op);
            st_d.of_rd    = in_rd;
            st_d.of_rs1   = in_rs1;
            st_d.of_rs2   = in_rs2;
        end else if (of_adv) begin
            st_d.of_valid = 1'b0;
        end
        st_d.wb_valid = ex_last;
        st_d.wb_rd    = ex_rd;
        st_d.wb_data  = ex_res;
        st_d.run      = st_q.run || accept;
        if (st_q.run || accept) st_d.cyc = st_q.cyc + CNTW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ret_valid = st_q.wb_valid;
    assign ret_rd    = st_q.wb_rd;
    assign ret_data  = st_q.wb_data;
    assign ret_cycle = st_q.cyc;

    // retirement order bookkeeping for checking only
    logic            seen_q;
    logic [CNTW-1:0] last_ret_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q     <= 1'b0;
            last_ret_q <= '0;
        end else if (ret_valid) begin
            seen_q     <= 1'b1;
            last_ret_q <= ret_cycle;
        end
    end

    // R4
    of_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.of_valid && !of_adv) |=> (st_q.of_valid && $stable(st_q.of_rd) && $stable(st_q.of_op)));

    // R7
    ret_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && seen_q) |-> (ret_cycle > last_ret_q));

    // R8
    cyc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.run |=> (ret_cycle == $past(ret_cycle) + CNTW'(1)));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.run |-> (!ret_valid && ret_cycle == '0));
endmodule

// File: tb/tb_varlat_pipe.sv
module tb_varlat_pipe;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [1:0]  in_op = '0;
    logic [3:0]  in_rd = '0, in_rs1 = '0, in_rs2 = '0;
    logic        ret_valid;
    logic [3:0]  ret_rd;
    logic [15:0] ret_data;
    logic [15:0] ret_cycle;

    always #(CLK_PERIOD/2) clk = ~clk;

    varlat_pipe dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .in_rd(in_rd), .in_rs1(in_rs1), .in_rs2(in_rs2),
        .ret_valid(ret_valid), .ret_rd(ret_rd), .ret_data(ret_data), .ret_cycle(ret_cycle)
    );

    typedef struct { logic [1:0] op; logic [3:0] rd, rs1, rs2; } ins_t;
    typedef struct { logic [3:0] rd; logic [15:0] data; int cyc; string tag; } exp_t;

    ins_t        prog[$];
    exp_t        exp_q[$];
    logic [15:0] rf_m [16];
    int          total = 0;
    int          bad = 0;
    int          last_cyc = -1;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    function automatic logic [15:0] alu(input logic [1:0] op, input logic [15:0] a, input logic [15:0] b);
        logic [31:0] p;
        case (op)
            2'b00: return a + b;
            2'b01: return a - b;
            2'b10: begin p = {16'h0, a} * {16'h0, b}; return p[15:0]; end
            default: return (b == 16'h0) ? 16'hFFFF : a / b;
        endcase
    endfunction

    function automatic int lat(input logic [1:0] op);
        return (op == 2'b10) ? 3 : (op == 2'b11) ? 5 : 1;
    endfunction

    // monitor: compare each retirement with the scoreboard (R7, R8)
    always @(negedge clk) begin
        if (rst_n && ret_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R7", "unexpected retire rd", int'(ret_rd), -1);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(ret_rd == e.rd, e.tag, "ret_rd", int'(ret_rd), int'(e.rd));
                chk(ret_data == e.data, e.tag, "ret_data", int'(ret_data), int'(e.data));
                chk(int'(ret_cycle) == e.cyc, e.tag, "ret_cycle", int'(ret_cycle), e.cyc);
            end
            last_cyc = int'(ret_cycle);
        end
    end

    task automatic do_reset();
        in_valid = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < 16; k++) rf_m[k] = 16'(k);
        @(negedge clk);
        // R1: reset state at the ports
        chk(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
        chk(ret_valid == 1'b0, "R1", "ret_valid after reset", int'(ret_valid), 0);
    endtask

    // driver: predict results and cycles, then stream the program back to back
    task automatic run_prog(input string tag);
        int acc_p = 0, exs_p = 0, exe_p = 0;
        for (int i = 0; i < prog.size(); i++) begin
            int acc, exs, exe;
            exp_t e;
            acc = (i == 0) ? 0 : ((acc_p + 1 > exs_p - 1) ? acc_p + 1 : exs_p - 1);
            exs = (i == 0) ? 2 : ((acc + 2 > exe_p + 1) ? acc + 2 : exe_p + 1);
            exe = exs + lat(prog[i].op) - 1;
            e.rd = prog[i].rd;
            e.data = alu(prog[i].op, rf_m[prog[i].rs1], rf_m[prog[i].rs2]);
            rf_m[prog[i].rd] = e.data;
            e.cyc = exe + 1;
            e.tag = tag;
            exp_q.push_back(e);
            acc_p = acc; exs_p = exs; exe_p = exe;
        end
        for (int i = 0; i < prog.size(); i++) begin
            in_valid = 1'b1;
            in_op = prog[i].op; in_rd = prog[i].rd;
            in_rs1 = prog[i].rs1; in_rs2 = prog[i].rs2;
            while (!in_ready) @(negedge clk);
            @(negedge clk);
        end
        in_valid = 1'b0;
        for (int w = 0; w < 60 && exp_q.size() > 0; w++) @(negedge clk);
        chk(exp_q.size() == 0, tag, "pending retirements", exp_q.size(), 0);
        exp_q.delete();
        repeat (4) @(negedge clk);
        prog.delete();
    endtask

    function automatic ins_t mk(input logic [1:0] op, input int rd, input int a, input int b);
        ins_t x;
        x.op = op; x.rd = 4'(rd); x.rs1 = 4'(a); x.rs2 = 4'(b);
        return x;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R3 R1: independent add/sub stream, one retirement per cycle
        do_reset();
        prog.push_back(mk(2'b00, 1, 2, 3));
        prog.push_back(mk(2'b01, 4, 5, 9));
        prog.push_back(mk(2'b00, 6, 7, 8));
        run_prog("R3");

        // R4 R5 R8: long multiply and divide with dependencies
        do_reset();
        prog.push_back(mk(2'b10, 2, 0, 1));
        prog.push_back(mk(2'b11, 5, 3, 4));
        prog.push_back(mk(2'b00, 2, 5, 2));
        prog.push_back(mk(2'b01, 5, 2, 6));
        run_prog("R4");
        chk(last_cyc == 12, "R8", "last retire cycle", last_cyc, 12);

        // R5: back-to-back dependent chain through execute forwarding
        do_reset();
        prog.push_back(mk(2'b00, 1, 1, 2));
        prog.push_back(mk(2'b00, 1, 1, 1));
        prog.push_back(mk(2'b01, 3, 1, 4));
        prog.push_back(mk(2'b10, 3, 3, 3));
        run_prog("R5");

        // R6: read in the same cycle as the producer's writeback
        do_reset();
        prog.push_back(mk(2'b00, 1, 2, 3));
        prog.push_back(mk(2'b00, 4, 5, 6));
        prog.push_back(mk(2'b00, 7, 1, 1));
        run_prog("R6");

        // R2: wrap, zero divisor, multiply overflow, plain divide
        do_reset();
        prog.push_back(mk(2'b01, 1, 0, 5));
        prog.push_back(mk(2'b11, 2, 9, 0));
        prog.push_back(mk(2'b10, 3, 1, 1));
        prog.push_back(mk(2'b11, 4, 15, 4));
        prog.push_back(mk(2'b10, 5, 2, 14));
        run_prog("R2");

        // R9: idle with garbage fields, counter must not start
        do_reset();
        for (int i = 0; i < 6; i++) begin
            in_valid = 1'b0;
            in_op = 2'(i); in_rd = 4'(i + 3); in_rs1 = 4'(15 - i); in_rs2 = 4'(i);
            @(negedge clk);
            chk(ret_valid == 1'b0, "R9", "ret_valid while idle", int'(ret_valid), 0);
            chk(ret_cycle == 16'h0, "R9", "counter while idle", int'(ret_cycle), 0);
        end
        prog.push_back(mk(2'b00, 8, 8, 3));
        prog.push_back(mk(2'b10, 9, 8, 8));
        prog.push_back(mk(2'b00, 10, 9, 8));
        run_prog("R9");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule